// File: doc/BRIEF.md
# Criticality-Aware Instruction Parking Stage

This stage sits between register rename and dispatch in an out-of-order core. Every renamed instruction arrives with a one-bit criticality flag. Critical instructions go straight to a registered dispatch slot: these are memory operations and the instructions that compute their addresses. Non-critical instructions are held back in a plain first-in first-out parking queue, so they claim no issue-queue entry and no physical register while they wait. This leaves the smaller downstream structures free for the instructions that expose memory-level parallelism. The default sizing assumes 32 issue-queue entries and 96 physical registers.

Parked instructions leave the queue from its head, one per cycle, in the order they arrived. A release needs two things. The first is a reason: a wake pulse, the latched effect of an earlier wake, or free-resource counts at or above programmable high marks. The second is at least one free issue slot and one free register. When a release and a critical arrival compete for the dispatch slot, the parked instruction goes first because it is older. A full queue does not stall rename: any further non-critical instruction takes the direct path. A flush empties the queue and discards the dispatch slot in a single cycle.

Top module: `crit_park_stage`

## Requirements
- R1: After reset the dispatch slot is empty (`out_valid` = 0), the parking queue is empty, and a non-critical instruction can be accepted (`in_ready` = 1 with `in_crit` = 0).
- R2: A critical instruction (`in_crit` = 1) accepted at a clock edge is in the dispatch slot right after that edge, with `out_from_park` = 0.
- R3: A non-critical instruction (`in_crit` = 0) accepted while the queue has room is parked. It does not show up on the dispatch output until a release condition holds.
- R4: Parked instructions are released with `out_from_park` = 1, strictly in arrival order.
- R5: No release takes place in a cycle where `iq_free` or `reg_free` is zero, whether or not `wake` is asserted.
- R6: A one-cycle `wake` pulse starts a drain. While credits allow, one parked instruction is released in each cycle that the dispatch slot can load, until the queue is empty.
- R7: A drain stops as soon as either credit count reaches zero. It does not resume when credits come back unless a new `wake` arrives or R8 applies.
- R8: While `iq_free` >= `IQ_MARK` (default 16) and `reg_free` >= `REG_MARK` (default 48), parked instructions are released without any `wake`.
- R9: While the queue holds `PARK_DEPTH` entries, a non-critical instruction is not stalled. It takes the direct path and appears with `out_from_park` = 0. The queue never holds more than `PARK_DEPTH` entries.
- R10: If a release and a critical arrival are possible in the same cycle, the release wins and `in_ready` is 0 for the critical instruction.
- R11: While `flush` is high, `in_ready` is 0. After the flush edge, the dispatch slot is empty and the queue holds no instructions.
- R12: While `out_valid` = 1 and `out_ready` = 0, the dispatch slot keeps its contents, and a critical instruction sees `in_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all parked instructions and the dispatch slot |
| in_valid | input | 1 | Renamed instruction present |
| in_ready | output | 1 | Instruction accepted this cycle if `in_valid` |
| in_crit | input | 1 | 1 = critical (memory access or address producer) |
| in_payload | input | PAYLOAD_W | Renamed instruction bits |
| out_valid | output | 1 | Dispatch slot holds an instruction |
| out_ready | input | 1 | Dispatch takes the slot contents this cycle |
| out_payload | output | PAYLOAD_W | Instruction in the dispatch slot |
| out_from_park | output | 1 | 1 = slot instruction came from the parking queue |
| iq_free | input | IQ_W | Free issue-queue entries downstream |
| reg_free | input | RG_W | Free physical registers downstream |
| wake | input | 1 | Pulse to start draining the parking queue |

## Verification
The only register between a decision and the ports is the dispatch slot. A direct or released instruction therefore becomes visible in the cycle after the edge that takes it, and a flush empties the slot at that same following edge. `in_ready` is combinational from this cycle's inputs and state. The bench drives stimulus just after a falling edge, waits one time unit for `in_ready` to settle and reads it, then checks the dispatch slot at the next falling edge, which comes one rising edge later. During a drain it steps one cycle per expected instruction, so each release is checked in exactly the cycle it is due, and the absence of output is checked over several later cycles.

// File: rtl/crit_park_pkg.sv
package crit_park_pkg;

  // Both downstream resources must have at least one free unit.
  function automatic logic credit_avail(input int unsigned iq, input int unsigned rg);
    return (iq != 0) && (rg != 0);
  endfunction

  // Both resources are plentiful enough that parked work may drain unprompted.
  function automatic logic above_marks(input int unsigned iq, input int unsigned rg,
                                       input int unsigned iq_mark, input int unsigned rg_mark);
    return (iq >= iq_mark) && (rg >= rg_mark);
  endfunction

  // Circular pointer advance for a queue of arbitrary depth.
  function automatic int unsigned ptr_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/crit_park_fifo.sv
module crit_park_fifo
  import crit_park_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  slot_q [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  // One write-enabled register per queue position.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = do_push && (wr_ptr == AW'(g));
    always_ff @(posedge clk) begin
      if (wr_en) slot_q[g] <= push_data;
    end
  end

  assign head_data = slot_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= AW'(ptr_next(32'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= AW'(ptr_next(32'(rd_ptr), DEPTH));
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/crit_park_release.sv
module crit_park_release
  import crit_park_pkg::*;
#(
  parameter int IQ_W    = 6,
  parameter int RG_W    = 7,
  parameter int IQ_MARK = 16,
  parameter int RG_MARK = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            wake,
  input  logic [IQ_W-1:0] iq_free,
  input  logic [RG_W-1:0] reg_free,
  input  logic            park_empty,
  input  logic            park_last,
  input  logic            park_push,
  input  logic            slot_free,
  output logic            credit_ok,
  output logic            release_fire,
  output logic            drain_active
);

  logic wake_q;
  logic mark_ok;
  logic want_release;
  logic drain_done;

  assign credit_ok    = credit_avail(32'(iq_free), 32'(reg_free));
  assign mark_ok      = above_marks(32'(iq_free), 32'(reg_free), IQ_MARK, RG_MARK);
  assign want_release = wake || wake_q || mark_ok;
  assign release_fire = want_release && credit_ok && !park_empty && slot_free && !flush;
  assign drain_done   = release_fire && park_last && !park_push;
  assign drain_active = wake_q;

  // Drain latch: set by a wake on a non-empty queue, dropped when credits
  // vanish, when the final entry leaves, or on flush.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wake_q <= 1'b0;
    end else if (!credit_ok) begin
      wake_q <= 1'b0;
    end else if (drain_done) begin
      wake_q <= 1'b0;
    end else if (wake && !park_empty) begin
      wake_q <= 1'b1;
    end
  end

endmodule

// File: rtl/crit_park_outreg.sv
module crit_park_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         load_from_park,
  input  logic         out_ready,
  output logic         slot_free,
  output logic         out_valid,
  output logic [W-1:0] out_payload,
  output logic         out_from_park
);

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      out_valid     <= 1'b0;
      out_payload   <= '0;
      out_from_park <= 1'b0;
    end else if (slot_free) begin
      out_valid <= load;
      if (load) begin
        out_payload   <= load_data;
        out_from_park <= load_from_park;
      end
    end
  end

endmodule

// File: rtl/crit_park_stage.sv
module crit_park_stage #(
  parameter int PAYLOAD_W   = 32,
  parameter int PARK_DEPTH  = 8,
  parameter int IQ_ENTRIES  = 32,
  parameter int REG_ENTRIES = 96,
  parameter int IQ_MARK     = 16,
  parameter int REG_MARK    = 48,
  localparam int IQ_W       = $clog2(IQ_ENTRIES + 1),
  localparam int RG_W       = $clog2(REG_ENTRIES + 1),
  localparam int PCW        = $clog2(PARK_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_crit,
  input  logic [PAYLOAD_W-1:0] in_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PAYLOAD_W-1:0] out_payload,
  output logic                 out_from_park,
  input  logic [IQ_W-1:0]      iq_free,
  input  logic [RG_W-1:0]      reg_free,
  input  logic                 wake
);

  // Named internal events, visible to the bound checker.
  logic                 park_full, park_empty, park_last;
  logic [PCW-1:0]       park_count;
  logic [PAYLOAD_W-1:0] park_head;
  logic                 park_push;
  logic                 slot_free;
  logic                 credit_ok;
  logic                 release_fire;
  logic                 drain_active;
  logic                 takes_direct;
  logic                 direct_fire;
  logic                 slot_load;

  assign park_last    = (park_count == PCW'(1));
  assign takes_direct = in_crit || park_full;

  always_comb begin
    if (flush)             in_ready = 1'b0;
    else if (takes_direct) in_ready = slot_free && !release_fire;
    else                   in_ready = 1'b1;
  end

  assign park_push   = in_valid && in_ready && !takes_direct;
  assign direct_fire = in_valid && in_ready && takes_direct;
  assign slot_load   = release_fire || direct_fire;

  crit_park_fifo #(
    .W     (PAYLOAD_W),
    .DEPTH (PARK_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (park_push),
    .push_data (in_payload),
    .pop       (release_fire),
    .head_data (park_head),
    .count     (park_count),
    .empty     (park_empty),
    .full      (park_full)
  );

  crit_park_release #(
    .IQ_W    (IQ_W),
    .RG_W    (RG_W),
    .IQ_MARK (IQ_MARK),
    .RG_MARK (REG_MARK)
  ) u_release (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .wake         (wake),
    .iq_free      (iq_free),
    .reg_free     (reg_free),
    .park_empty   (park_empty),
    .park_last    (park_last),
    .park_push    (park_push),
    .slot_free    (slot_free),
    .credit_ok    (credit_ok),
    .release_fire (release_fire),
    .drain_active (drain_active)
  );

  crit_park_outreg #(
    .W (PAYLOAD_W)
  ) u_out (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .load           (slot_load),
    .load_data      (release_fire ? park_head : in_payload),
    .load_from_park (release_fire),
    .out_ready      (out_ready),
    .slot_free      (slot_free),
    .out_valid      (out_valid),
    .out_payload    (out_payload),
    .out_from_park  (out_from_park)
  );

endmodule

// File: rtl/crit_park_checker.sv
module crit_park_checker #(
  parameter int W    = 32,
  parameter int DEPTH = 8,
  parameter int CW   = 4,
  parameter int IQ_W = 6,
  parameter int RG_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_crit,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_payload,
  input logic            out_from_park,
  input logic [IQ_W-1:0] iq_free,
  input logic [RG_W-1:0] reg_free,
  input logic            release_fire,
  input logic            park_push,
  input logic            park_full,
  input logic            drain_active,
  input logic [CW-1:0]   park_count
);

  assert_direct_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_crit) |=> (out_valid && !out_from_park));

  assert_release_tagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    release_fire |=> (out_valid && out_from_park));

  assert_credit_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_fire |-> (iq_free != '0 && reg_free != '0));

  assert_drain_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_free == '0) |=> !drain_active);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    park_push |-> !park_full);

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    park_count <= CW'(DEPTH));

  assert_park_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (release_fire && in_valid && in_crit) |-> !in_ready);

  assert_flush_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && park_count == '0));

  assert_slot_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_payload)));

endmodule

bind crit_park_stage crit_park_checker #(
  .W     (PAYLOAD_W),
  .DEPTH (PARK_DEPTH),
  .CW    (PCW),
  .IQ_W  (IQ_W),
  .RG_W  (RG_W)
) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_crit       (in_crit),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_payload   (out_payload),
  .out_from_park (out_from_park),
  .iq_free       (iq_free),
  .reg_free      (reg_free),
  .release_fire  (release_fire),
  .park_push     (park_push),
  .park_full     (park_full),
  .drain_active  (drain_active),
  .park_count    (park_count)
);

// File: tb/test_crit_park_stage.sv
`timescale 1ns/1ps
module test_crit_park_stage;

  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_crit = 1'b0;
  logic [PW-1:0] in_payload = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PW-1:0] out_payload;
  logic          out_from_park;
  logic [5:0]    iq_free = 6'd4;
  logic [6:0]    reg_free = 7'd4;
  logic          wake = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  crit_park_stage i_crit_park_stage (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_crit       (in_crit),
    .in_payload    (in_payload),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_payload   (out_payload),
    .out_from_park (out_from_park),
    .iq_free       (iq_free),
    .reg_free      (reg_free),
    .wake          (wake)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_slot(string req, logic v, logic [PW-1:0] p, logic fp);
    checks++;
    if (out_valid !== v || (v && (out_payload !== p || out_from_park !== fp))) begin
      fails++;
      $display("FAIL %s: slot valid=%0b data=%h park=%0b, expected valid=%0b data=%h park=%0b",
               req, out_valid, out_payload, out_from_park, v, p, fp);
    end
  endtask

  task automatic expect_ready(string req, logic exp);
    #1;
    checks++;
    if (in_ready !== exp) begin
      fails++;
      $display("FAIL %s: in_ready=%0b, expected %0b", req, in_ready, exp);
    end
  endtask

  // Offer one instruction for a single edge; it must be accepted.
  task automatic send(string req, logic [PW-1:0] p, logic crit);
    in_valid = 1'b1; in_crit = crit; in_payload = p;
    expect_ready(req, 1'b1);
    tick();
    in_valid = 1'b0; in_crit = 1'b0;
  endtask

  task automatic t_reset();
    expect_slot("R1", 1'b0, '0, 1'b0);
    expect_ready("R1", 1'b1);
  endtask

  task automatic t_direct();
    send("R2", 32'h11, 1'b1);
    expect_slot("R2", 1'b1, 32'h11, 1'b0);
    tick();
    expect_slot("R2", 1'b0, '0, 1'b0);
  endtask

  task automatic t_park_hold();
    send("R3", 32'h21, 1'b0); expect_slot("R3", 1'b0, '0, 1'b0);
    send("R3", 32'h22, 1'b0); expect_slot("R3", 1'b0, '0, 1'b0);
    send("R3", 32'h23, 1'b0); expect_slot("R3", 1'b0, '0, 1'b0);
    tick(); tick();
    expect_slot("R3", 1'b0, '0, 1'b0);
  endtask

  task automatic t_no_credit();
    iq_free = 6'd0; wake = 1'b1;
    tick();
    wake = 1'b0;
    expect_slot("R5", 1'b0, '0, 1'b0);
    iq_free = 6'd4;
    tick(); tick();
    expect_slot("R7", 1'b0, '0, 1'b0);
  endtask

  task automatic t_wake_drain();
    wake = 1'b1;
    tick();
    wake = 1'b0;
    expect_slot("R6", 1'b1, 32'h21, 1'b1);
    tick(); expect_slot("R4", 1'b1, 32'h22, 1'b1);
    tick(); expect_slot("R4", 1'b1, 32'h23, 1'b1);
    tick(); expect_slot("R6", 1'b0, '0, 1'b0);
  endtask

  task automatic t_credit_stop();
    send("R7", 32'h31, 1'b0);
    send("R7", 32'h32, 1'b0);
    send("R7", 32'h33, 1'b0);
    wake = 1'b1;
    tick();
    wake = 1'b0; reg_free = 7'd0;
    expect_slot("R7", 1'b1, 32'h31, 1'b1);
    tick();
    expect_slot("R7", 1'b0, '0, 1'b0);
    reg_free = 7'd4;
    tick(); tick();
    expect_slot("R7", 1'b0, '0, 1'b0);
    wake = 1'b1;
    tick();
    wake = 1'b0;
    expect_slot("R7", 1'b1, 32'h32, 1'b1);
    tick(); expect_slot("R4", 1'b1, 32'h33, 1'b1);
    tick(); expect_slot("R7", 1'b0, '0, 1'b0);
  endtask

  task automatic t_high_mark();
    send("R8", 32'h41, 1'b0);
    expect_slot("R8", 1'b0, '0, 1'b0);
    iq_free = 6'd20; reg_free = 7'd60;
    tick();
    expect_slot("R8", 1'b1, 32'h41, 1'b1);
    iq_free = 6'd4; reg_free = 7'd4;
    tick();
    expect_slot("R8", 1'b0, '0, 1'b0);
  endtask

  task automatic t_priority();
    send("R10", 32'h51, 1'b0);
    wake = 1'b1;
    in_valid = 1'b1; in_crit = 1'b1; in_payload = 32'h52;
    expect_ready("R10", 1'b0);
    tick();
    wake = 1'b0;
    expect_slot("R10", 1'b1, 32'h51, 1'b1);
    expect_ready("R10", 1'b1);
    tick();
    in_valid = 1'b0; in_crit = 1'b0;
    expect_slot("R10", 1'b1, 32'h52, 1'b0);
    tick();
    expect_slot("R10", 1'b0, '0, 1'b0);
  endtask

  task automatic t_full_divert();
    for (int k = 0; k < 8; k++) send("R9", 32'h60 + 32'(k), 1'b0);
    expect_slot("R9", 1'b0, '0, 1'b0);
    send("R9", 32'h68, 1'b0);
    expect_slot("R9", 1'b1, 32'h68, 1'b0);
    tick();
    expect_slot("R9", 1'b0, '0, 1'b0);
    wake = 1'b1;
    tick();
    wake = 1'b0;
    for (int k = 0; k < 8; k++) begin
      expect_slot("R4", 1'b1, 32'h60 + 32'(k), 1'b1);
      tick();
    end
    expect_slot("R6", 1'b0, '0, 1'b0);
  endtask

  task automatic t_stall();
    out_ready = 1'b0;
    send("R12", 32'h71, 1'b1);
    expect_slot("R12", 1'b1, 32'h71, 1'b0);
    in_valid = 1'b1; in_crit = 1'b1; in_payload = 32'h72;
    expect_ready("R12", 1'b0);
    tick();
    expect_slot("R12", 1'b1, 32'h71, 1'b0);
    expect_ready("R12", 1'b0);
    tick();
    expect_slot("R12", 1'b1, 32'h71, 1'b0);
    out_ready = 1'b1;
    expect_ready("R12", 1'b1);
    tick();
    in_valid = 1'b0; in_crit = 1'b0;
    expect_slot("R12", 1'b1, 32'h72, 1'b0);
    tick();
    expect_slot("R12", 1'b0, '0, 1'b0);
  endtask

  task automatic t_flush();
    send("R11", 32'h81, 1'b0);
    send("R11", 32'h82, 1'b0);
    out_ready = 1'b0;
    send("R11", 32'h83, 1'b1);
    expect_slot("R11", 1'b1, 32'h83, 1'b0);
    flush = 1'b1;
    expect_ready("R11", 1'b0);
    tick();
    flush = 1'b0;
    expect_slot("R11", 1'b0, '0, 1'b0);
    out_ready = 1'b1; wake = 1'b1;
    tick();
    wake = 1'b0;
    expect_slot("R11", 1'b0, '0, 1'b0);
    tick();
    expect_slot("R11", 1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_direct();
    t_park_hold();
    t_no_credit();
    t_wake_drain();
    t_credit_stop();
    t_high_mark();
    t_priority();
    t_full_divert();
    t_stall();
    t_flush();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule